// File: doc/BRIEF.md
# Prioritised Interrupt Collector

This block merges up to 128 level-sensitive interrupt inputs into a single processor interrupt. Software configures each input through its own small configuration word, which holds an enable flag and a two-bit priority. A status word names the input the processor should handle next. That choice is the lowest-numbered active input within the highest eligible priority.

All registers sit on a simple 32-bit word bus with a combinational read path. Every register is decoded at four consecutive word addresses. The first address is an ordinary read/write view. The other three set, clear or toggle the bits that are written as 1. This lets firmware mask or unmask one input with a single write and no read-modify-write.

The service handshake works per priority. Software reads the status word and writes that number to the vector register. This marks the winner's priority as in service, and from then on only strictly higher priorities can interrupt. A write to the level-acknowledge register later ends service for the priorities it names.

Top module: `icol_top`

## Requirements
- R1: Each register has four views at byte offsets +0x0 (write data replaces the register), +0x4 (written ones are set), +0x8 (written ones are cleared) and +0xC (written ones are toggled). Accesses whose byte address has bits [1:0] not equal to zero are ignored and read as 0.
- R2: A read through any of the four views returns the same value as the plain view.
- R3: The configuration word of input n is at byte address 0x120 + 0x10*n. Bits [1:0] hold the priority (3 is the highest) and bit 2 is the enable. All other bits read as 0.
- R4: After reset, every configuration word, the control word, the vector word and the in-service flags read 0, and irq_o is 0.
- R5: The status word at 0x070 holds, in its low bits, the number of the winning input. The winner is taken from the eligible priority with the most urgent level, and within that level it is the lowest-numbered input that is both sampled high and enabled. When there is no winner, the status word reads 0x8000_0000.
- R6: irq_o is a registered signal. It is high one clock after a winner exists while control bit 0 (global enable) is 1, and it is low otherwise.
- R7: A write to the vector word at 0x000 stores the data through the view logic. If a winner exists at that moment, the write also sets the in-service flag for the winner's priority. While any flag is set, only inputs whose priority is strictly above the highest flagged priority are eligible.
- R8: A write to the level-acknowledge register at 0x010, through any view, clears each in-service flag whose bit is 1 in write data bits [3:0]. Bit k of that data stands for priority k. A read of the register returns the flags in bits [3:0].
- R9: The status word is read-only. Writes to any of its views change no register.
- R10: A write to the control word at 0x020 that results in bit 31 being 1 is a soft reset. It clears all configuration words, the control word, the vector word, the in-service flags and irq_o. Bit 31 always reads 0.
- R11: Inputs are sampled every clock. An input that drops before it is serviced leaves the selection with no software action.
- R12: The vector word reads back the last value produced by the view logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level interrupt inputs |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 1 | Processor interrupt |

## Verification
The bench drives cases where a higher-priority input with a larger number must beat a lower-numbered one. A selector that scans numbers before priorities would report the wrong input there. It sets a priority in service and checks that inputs at and below that priority are held off while a strictly higher one still interrupts. An off-by-one in the threshold would either block the higher input or let an equal one through. The bench also checks that the status views ignore writes, that inputs 0 and 127 decode at the ends of the map, and that the soft reset clears the whole configuration. A decoder that slipped one register, or a soft reset that missed the in-service flags, shows up as a wrong read-back.

// File: rtl/icol_pkg.sv
`timescale 1ns/1ps
package icol_pkg;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned CFG_W   = 3;

  typedef enum logic [1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_SET   = 2'd1,
    VIEW_CLR   = 2'd2,
    VIEW_TOG   = 2'd3
  } view_e;

  function automatic logic view_bit(input logic old_v, input logic wd, input view_e v);
    case (v)
      VIEW_PLAIN: return wd;
      VIEW_SET:   return old_v | wd;
      VIEW_CLR:   return old_v & ~wd;
      default:    return old_v ^ wd;
    endcase
  endfunction

  function automatic logic [CFG_W-1:0] view_cfg(input logic [CFG_W-1:0] old_v,
                                                input logic [CFG_W-1:0] wd, input view_e v);
    case (v)
      VIEW_PLAIN: return wd;
      VIEW_SET:   return old_v | wd;
      VIEW_CLR:   return old_v & ~wd;
      default:    return old_v ^ wd;
    endcase
  endfunction

  function automatic logic [31:0] view_word(input logic [31:0] old_v, input logic [31:0] wd,
                                            input view_e v);
    case (v)
      VIEW_PLAIN: return wd;
      VIEW_SET:   return old_v | wd;
      VIEW_CLR:   return old_v & ~wd;
      default:    return old_v ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/icol_src_bank.sv
`timescale 1ns/1ps
module icol_src_bank
  import icol_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            soft_rst_i,
  input  logic                            wr_i,
  input  logic [SRC_W-1:0]                wr_idx_i,
  input  view_e                           view_i,
  input  logic [CFG_W-1:0]                wdata_i,
  input  logic [SRC_W-1:0]                rd_idx_i,
  output logic [CFG_W-1:0]                rd_cfg_o,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o
);
  logic [NUM_SRC-1:0][CFG_W-1:0] cfg_all;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [CFG_W-1:0] cfg_q;
    logic             hit;
    assign hit = wr_i && (wr_idx_i == SRC_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cfg_q <= '0;
      else if (soft_rst_i) cfg_q <= '0;
      else if (hit)        cfg_q <= view_cfg(cfg_q, wdata_i, view_i);
    end

    assign cfg_all[i] = cfg_q;
    assign en_o[i]    = cfg_q[2];
    assign lvl_o[i]   = cfg_q[LVL_W-1:0];
  end

  assign rd_cfg_o = cfg_all[rd_idx_i];

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (en_o == '0) && (lvl_o == '0)); // R10

  AST_WRITE_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !soft_rst_i |=> $stable(en_o) && $stable(lvl_o)); // R3
endmodule

// File: rtl/icol_arbiter.sv
`timescale 1ns/1ps
module icol_arbiter
  import icol_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            active_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [NUM_LVL-1:0]            inserv_i,
  output logic                          win_valid_o,
  output logic [SRC_W-1:0]              win_idx_o,
  output logic [LVL_W-1:0]              win_lvl_o
);
  logic [NUM_LVL-1:0]              elig_lvl;
  logic [NUM_LVL-1:0][NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0]              sel;
  logic [LVL_W-1:0]                ceil_lvl;

  // highest level currently in service
  always_comb begin
    ceil_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inserv_i[l]) ceil_lvl = LVL_W'(l);
    for (int l = 0; l < NUM_LVL; l++)
      elig_lvl[l] = !(|inserv_i) || (LVL_W'(l) > ceil_lvl);
  end

  always_comb begin
    for (int l = 0; l < NUM_LVL; l++)
      for (int s = 0; s < NUM_SRC; s++)
        cand[l][s] = active_i[s] && (lvl_i[s] == LVL_W'(l)) && elig_lvl[l];
  end

  // most urgent non-empty level, then lowest index within it
  always_comb begin
    win_valid_o = 1'b0;
    win_lvl_o   = '0;
    sel         = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (|cand[l]) begin
        win_valid_o = 1'b1;
        win_lvl_o   = LVL_W'(l);
        sel         = cand[l];
      end
    end
    win_idx_o = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--)
      if (sel[s]) win_idx_o = SRC_W'(s);
  end

  AST_WIN_IS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> active_i[win_idx_o] && (lvl_i[win_idx_o] == win_lvl_o)); // R5

  AST_NO_WIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|active_i) |-> !win_valid_o); // R5

  AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> !inserv_i[win_lvl_o]); // R7
endmodule

// File: rtl/icol_svc_track.sv
`timescale 1ns/1ps
module icol_svc_track
  import icol_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               enter_i,
  input  logic               enter_ok_i,
  input  logic [LVL_W-1:0]   enter_lvl_i,
  input  logic               ack_i,
  input  logic [NUM_LVL-1:0] ack_bits_i,
  output logic [NUM_LVL-1:0] inserv_o
);
  logic [NUM_LVL-1:0] inserv_q, set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    if (enter_i && enter_ok_i) set_mask[enter_lvl_i] = 1'b1;
    clr_mask = ack_i ? ack_bits_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         inserv_q <= '0;
    else if (soft_rst_i) inserv_q <= '0;
    else                 inserv_q <= (inserv_q & ~clr_mask) | set_mask;
  end

  assign inserv_o = inserv_q;

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !enter_i |=> (inserv_o & $past(ack_bits_i)) == '0); // R8

  AST_ENTER_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i && enter_ok_i && !soft_rst_i |=> inserv_o[$past(enter_lvl_i)]); // R7
endmodule

// File: rtl/icol_top.sv
`timescale 1ns/1ps
module icol_top
  import icol_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  localparam int unsigned SRC_W = $clog2(NUM_SRC);
  localparam int unsigned IDX_W = ADDR_W - 4;
  localparam logic [IDX_W-1:0] IDX_VEC     = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_LACK    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CTRL    = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_STAT    = IDX_W'(7);
  localparam logic [IDX_W-1:0] IDX_SRC0    = IDX_W'(18);
  localparam logic [IDX_W-1:0] IDX_SRC_END = IDX_W'(18 + NUM_SRC);

  logic [IDX_W-1:0] reg_idx;
  view_e            view;
  logic             aligned, wr, rd, src_hit;
  logic [SRC_W-1:0] src_sel;
  logic             vec_we, ack_we, ctrl_we, stat_we, src_we, soft_rst;

  assign reg_idx = addr_i[ADDR_W-1:4];
  assign view    = view_e'(addr_i[3:2]);
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i && aligned;
  assign src_hit = (reg_idx >= IDX_SRC0) && (reg_idx < IDX_SRC_END);
  assign src_sel = SRC_W'(reg_idx - IDX_SRC0);

  assign vec_we   = wr && (reg_idx == IDX_VEC);
  assign ack_we   = wr && (reg_idx == IDX_LACK);
  assign ctrl_we  = wr && (reg_idx == IDX_CTRL);
  assign stat_we  = wr && (reg_idx == IDX_STAT);
  assign src_we   = wr && src_hit;
  assign soft_rst = ctrl_we && view_bit(1'b0, wdata_i[31], view);

  // input sampling
  logic [NUM_SRC-1:0] src_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  // control and vector words
  logic        ctrl_en_q;
  logic [31:0] vector_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      vector_q  <= '0;
    end else if (soft_rst) begin
      ctrl_en_q <= 1'b0;
      vector_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_en_q <= view_bit(ctrl_en_q, wdata_i[0], view);
      if (vec_we)  vector_q  <= view_word(vector_q, wdata_i, view);
    end
  end

  logic [NUM_SRC-1:0]            en;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [CFG_W-1:0]              rd_cfg;

  icol_src_bank #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_bank (
    .clk_i, .rst_ni,
    .soft_rst_i (soft_rst),
    .wr_i       (src_we),
    .wr_idx_i   (src_sel),
    .view_i     (view),
    .wdata_i    (wdata_i[CFG_W-1:0]),
    .rd_idx_i   (src_sel),
    .rd_cfg_o   (rd_cfg),
    .en_o       (en),
    .lvl_o      (lvl)
  );

  logic [NUM_LVL-1:0] inserv;
  logic               win_valid;
  logic [SRC_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;

  icol_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .clk_i, .rst_ni,
    .active_i    (src_q & en),
    .lvl_i       (lvl),
    .inserv_i    (inserv),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl)
  );

  icol_svc_track u_svc (
    .clk_i, .rst_ni,
    .soft_rst_i  (soft_rst),
    .enter_i     (vec_we),
    .enter_ok_i  (win_valid),
    .enter_lvl_i (win_lvl),
    .ack_i       (ack_we),
    .ack_bits_i  (wdata_i[NUM_LVL-1:0]),
    .inserv_o    (inserv)
  );

  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (soft_rst) irq_q <= 1'b0;
    else               irq_q <= ctrl_en_q && win_valid;
  end
  assign irq_o = irq_q;

  logic [31:0] status;
  assign status = win_valid ? 32'(win_idx) : 32'h8000_0000;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (reg_idx)
        IDX_VEC:  rdata_o = vector_q;
        IDX_LACK: rdata_o = 32'(inserv);
        IDX_CTRL: rdata_o = {31'b0, ctrl_en_q};
        IDX_STAT: rdata_o = status;
        default:  rdata_o = src_hit ? 32'(rd_cfg) : '0;
      endcase
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctrl_en_q)); // R6

  AST_STAT_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we |=> $stable(ctrl_en_q) && $stable(vector_q) && $stable(inserv)); // R9
endmodule

// File: tb/sim_icol_top.sv
`timescale 1ns/1ps
module sim_icol_top;
  localparam int NSRC = 128;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            req = 1'b0, we = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  icol_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [11:0] A_VEC = 12'h000, A_LACK = 12'h010, A_CTRL = 12'h020, A_STAT = 12'h070;
  localparam logic [31:0] NONE = 32'h8000_0000;

  function automatic logic [11:0] cfg_addr(input int n);
    return 12'(12'h120 + n * 16);
  endfunction

  task automatic check(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req_tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d);       check("R4 ctrl", d, 0);
    rd(A_LACK, d);       check("R4 inserv", d, 0);
    rd(A_VEC, d);        check("R4 vector", d, 0);
    rd(cfg_addr(0), d);  check("R4 cfg0", d, 0);
    rd(cfg_addr(127), d);check("R4 cfg127", d, 0);
    rd(A_STAT, d);       check("R5 idle status", d, NONE);
    check("R4 irq", 32'(irq), 0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(cfg_addr(10), 32'hFFFF_FFFF);
    rd(cfg_addr(10), d);       check("R3 unused bits", d, 32'h7);
    wr(cfg_addr(10) + 8, 32'h5);
    rd(cfg_addr(10), d);       check("R1 clear view", d, 32'h2);
    wr(cfg_addr(10) + 4, 32'h4);
    rd(cfg_addr(10), d);       check("R1 set view", d, 32'h6);
    wr(cfg_addr(10) + 12, 32'h3);
    rd(cfg_addr(10), d);       check("R1 toggle view", d, 32'h5);
    rd(cfg_addr(10) + 4, d);   check("R2 read set view", d, 32'h5);
    rd(cfg_addr(10) + 8, d);   check("R2 read clr view", d, 32'h5);
    rd(cfg_addr(10) + 12, d);  check("R2 read tog view", d, 32'h5);
    wr(cfg_addr(10) + 2, 32'h0);
    rd(cfg_addr(10), d);       check("R1 unaligned ignored", d, 32'h5);
    wr(cfg_addr(10), 32'h0);
    wr(A_VEC, 32'h1234);
    wr(A_VEC + 4, 32'h8000);
    rd(A_VEC, d);              check("R12 vector view", d, 32'h9234);
    rd(A_LACK, d);             check("R7 no winner no flag", d, 0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(A_CTRL + 4, 32'h1);
    wr(cfg_addr(9) + 4, 32'h4);
    wr(cfg_addr(3) + 4, 32'h4);
    src[9] = 1'b1; src[3] = 1'b1;
    settle();
    rd(A_STAT, d);  check("R5 lowest number", d, 3);
    check("R6 irq raised", 32'(irq), 1);
    wr(cfg_addr(20), 32'h6);
    src[20] = 1'b1;
    settle();
    rd(A_STAT, d);  check("R5 level beats number", d, 20);
    wr(A_CTRL + 8, 32'h1);
    settle();
    check("R6 global gate", 32'(irq), 0);
    rd(A_STAT, d);  check("R6 status ungated", d, 20);
    wr(A_CTRL + 4, 32'h1);
    settle();
    check("R6 irq back", 32'(irq), 1);
  endtask

  task automatic t_service();
    logic [31:0] d;
    rd(A_STAT, d);
    wr(A_VEC, d);
    settle();
    rd(A_LACK, d);  check("R8 flag level 2", d, 32'h4);
    rd(A_STAT, d);  check("R7 lower held off", d, NONE);
    check("R7 irq held", 32'(irq), 0);
    wr(cfg_addr(30), 32'h6);
    src[30] = 1'b1;
    settle();
    rd(A_STAT, d);  check("R7 equal level held off", d, NONE);
    wr(cfg_addr(40), 32'h7);
    src[40] = 1'b1;
    settle();
    rd(A_STAT, d);  check("R7 higher preempts", d, 40);
    check("R7 irq higher", 32'(irq), 1);
    src[40] = 1'b0; src[30] = 1'b0;
    wr(cfg_addr(40), 32'h0);
    wr(cfg_addr(30), 32'h0);
    wr(A_LACK + 4, 32'h4);
    settle();
    rd(A_LACK, d);  check("R8 flag cleared", d, 0);
    rd(A_STAT, d);  check("R8 resume", d, 20);
    check("R8 irq resume", 32'(irq), 1);
  endtask

  task automatic t_drop();
    logic [31:0] d;
    src[20] = 1'b0;
    settle();
    rd(A_STAT, d);  check("R11 drop out", d, 3);
    wr(cfg_addr(3) + 8, 32'h4);
    settle();
    rd(A_STAT, d);  check("R3 masked via clear", d, 9);
    src[9] = 1'b0;
    settle();
    rd(A_STAT, d);  check("R11 none left", d, NONE);
    check("R11 irq low", 32'(irq), 0);
  endtask

  task automatic t_status_ro();
    logic [31:0] d, v0;
    rd(A_VEC, v0);
    for (int k = 0; k < 4; k++) wr(A_STAT + 12'(k * 4), 32'hFFFF_FFFF);
    rd(A_STAT, d);  check("R9 status", d, NONE);
    rd(A_VEC, d);   check("R9 vector kept", d, v0);
    rd(A_CTRL, d);  check("R9 ctrl kept", d, 32'h1);
    rd(A_LACK, d);  check("R9 flags kept", d, 0);
  endtask

  task automatic t_boundary();
    logic [31:0] d;
    wr(cfg_addr(127), 32'h7);
    wr(cfg_addr(0), 32'h7);
    rd(cfg_addr(127), d); check("R3 last source", d, 32'h7);
    src[127] = 1'b1; src[0] = 1'b1;
    settle();
    rd(A_STAT, d);  check("R5 source 0", d, 0);
    src[0] = 1'b0;
    settle();
    rd(A_STAT, d);  check("R5 source 127", d, 127);
  endtask

  task automatic t_softrst();
    logic [31:0] d;
    rd(A_STAT, d);
    wr(A_VEC, d);
    rd(A_LACK, d);  check("R7 flag level 3", d, 32'h8);
    wr(A_CTRL + 4, 32'h8000_0000);
    settle();
    rd(cfg_addr(127), d); check("R10 cfg cleared", d, 0);
    rd(A_CTRL, d);  check("R10 ctrl cleared", d, 0);
    rd(A_LACK, d);  check("R10 flags cleared", d, 0);
    rd(A_VEC, d);   check("R10 vector cleared", d, 0);
    rd(A_STAT, d);  check("R10 no winner", d, NONE);
    check("R10 irq low", 32'(irq), 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_select();
    t_service();
    t_drop();
    t_status_ro();
    t_boundary();
    t_softrst();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule